// File: doc/BRIEF.md
# Nested Page Fault Syndrome Encoder

This block sits beside a second-stage (nested) page-table walker. For each translation it takes the permissions the walker has gathered, the kind of access requested, any fault the walker found on its own, and a flag saying whether the access was a table read made by the walk or the final guest data access. It then decides whether the access is allowed.

On success it reports a read/write/execute permission mask, with the rights the page does not grant taken out. On failure it builds a 64-bit exit-information syndrome for the hypervisor, latches the faulting guest-physical address and raises a one-cycle fault strobe.

All outputs are registered. Each valid input shows its result one clock later, and the outputs hold that result until the next valid input arrives. The block does not sequence the walk and does not touch memory.

Top module: `npf_syn_enc`

## Requirements
- R1: A result appears on the outputs one clock after the edge that samples `in_valid` high. While `in_valid` is low, `perm_mask`, `syndrome` and `fault_gpa` hold their values and every other input is ignored.
- R2: With the walker class code 0 (none), a clear `prot_user` gives a protection fault for every access kind.
- R3: With `prot_nx` set, an instruction fetch (access code 2) faults. Any other allowed access is granted with the execute bit (`perm_mask[2]`) clear.
- R4: With `prot_write` clear, a store (access code 1) faults. Any other allowed access is granted with the write bit (`perm_mask[1]`) clear.
- R5: A granted access sets `perm_mask[0]` (read), `perm_mask[1]` equal to `prot_write` and `perm_mask[2]` equal to the inverse of `prot_nx`. `syndrome` is zero and `fault_valid` stays low.
- R6: Walker class codes are 1 not-present, 2 protection and 3 reserved-bit. A walker class other than 0 takes precedence over the permission check. `syndrome[0]` is set for protection and reserved-bit faults. `syndrome[3]` is set only for reserved-bit faults.
- R7: Every fault sets `syndrome[2]`.
- R8: Access codes are 0 read, 1 store, 2 fetch, and 3 is treated as a read. On a fault, `syndrome[1]` is set for a store and `syndrome[4]` for a fetch. All other syndrome bits outside 0 to 4, 32 and 33 are zero.
- R9: On a fault, `syndrome[32]` is set when `walk_access` is 0 and `syndrome[33]` when it is 1. Exactly one of the two is set.
- R10: `fault_gpa` takes `gpa` only on a fault and keeps it through later granted accesses.
- R11: `fault_valid` is a single-cycle pulse. `perm_mask` is zero after a fault.
- R12: Synchronous active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs carry a request this cycle |
| prot_user | input | 1 | Accumulated user-permitted bit |
| prot_write | input | 1 | Accumulated write-permitted bit |
| prot_nx | input | 1 | Accumulated no-execute bit |
| access_kind | input | 2 | 0 read, 1 store, 2 fetch, 3 read |
| walk_class | input | 2 | Walker fault: 0 none, 1 not-present, 2 protection, 3 reserved-bit |
| walk_access | input | 1 | 1 for a table-walk access, 0 for the final access |
| gpa | input | GPA_W | Guest-physical address of the access |
| perm_mask | output | 3 | Granted rights: bit 0 read, bit 1 write, bit 2 execute |
| fault_valid | output | 1 | One-cycle fault strobe |
| syndrome | output | 64 | Exit-information word |
| fault_gpa | output | GPA_W | Latched faulting guest-physical address |

## Verification
The hardest case to reach from the ports is a fault that the walker reports at the same time as a permission problem. Here the walker's class must win, and the protection bit must not be merged in a second time. The bench sweeps every combination of the three permission bits, the four access codes, the four walker classes and the walk flag. Each request is followed by an idle cycle in which every other input is inverted, so that both the held outputs and the single-cycle strobe are checked after each fault and each grant.

// File: rtl/npf_syn_pkg.sv
// Shared encodings for the nested page fault syndrome encoder.
// Assumes a 64-bit exit-information word; bit positions are fixed by the consumer.
package npf_syn_pkg;
    localparam int SYN_W       = 64;
    localparam int SB_PROT     = 0;
    localparam int SB_WRITE    = 1;
    localparam int SB_USER     = 2;
    localparam int SB_RSVD     = 3;
    localparam int SB_FETCH    = 4;
    localparam int SB_FINAL    = 32;
    localparam int SB_TABLE    = 33;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FC_NONE   = 2'd0,
        FC_ABSENT = 2'd1,
        FC_PROT   = 2'd2,
        FC_RSVD   = 2'd3
    } fault_cls_e;

    typedef struct packed {
        logic exec;
        logic write;
        logic read;
    } perm_t;
endpackage

// File: rtl/npf_perm_check.sv
// Permission evaluator: compares the accumulated page rights with the
// requested access kind. Purely combinational; assumes the rights are final.
module npf_perm_check
    import npf_syn_pkg::*;
(
    input  logic      user_ok,
    input  logic      write_ok,
    input  logic      no_exec,
    input  acc_kind_e kind,
    output logic      violation,
    output perm_t     granted
);
    // Decide whether the access breaks a right and trim the grant mask.
    always_comb begin
        violation     = 1'b0;
        granted.read  = 1'b1;
        granted.write = write_ok;
        granted.exec  = ~no_exec;
        if (!user_ok) begin
            violation = 1'b1;
        end
        if (no_exec && kind == ACC_FETCH) begin
            violation = 1'b1;
        end
        if (!write_ok && kind == ACC_STORE) begin
            violation = 1'b1;
        end
    end
endmodule

// File: rtl/npf_syn_build.sv
// Syndrome builder: turns a resolved fault class, access kind and walk flag
// into the exit-information word. Yields zero when the class is FC_NONE.
module npf_syn_build
    import npf_syn_pkg::*;
(
    input  fault_cls_e        cls,
    input  acc_kind_e         kind,
    input  logic              table_walk,
    output logic [SYN_W-1:0]  word
);
    // Cascade the class bits and add the access-kind bits.
    always_comb begin
        word = '0;
        if (cls != FC_NONE) begin
            word[SB_USER]  = 1'b1;
            word[SB_PROT]  = (cls == FC_PROT) || (cls == FC_RSVD);
            word[SB_RSVD]  = (cls == FC_RSVD);
            word[SB_WRITE] = (kind == ACC_STORE);
            word[SB_FETCH] = (kind == ACC_FETCH);
            word[SB_FINAL] = ~table_walk;
            word[SB_TABLE] = table_walk;
        end
    end
endmodule

// File: rtl/npf_out_reg.sv
// Output stage: captures a result on each valid request, holds it otherwise,
// pulses the fault strobe for one cycle and latches the address on faults.
module npf_out_reg
    import npf_syn_pkg::*;
#(
    parameter int GPA_W = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              is_fault,
    input  perm_t             mask_in,
    input  logic [SYN_W-1:0]  syn_in,
    input  logic [GPA_W-1:0]  addr_in,
    output perm_t             mask_q,
    output logic              strobe_q,
    output logic [SYN_W-1:0]  syn_q,
    output logic [GPA_W-1:0]  addr_q
);
    // Register the result; the address moves only on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            strobe_q <= 1'b0;
            syn_q    <= '0;
            addr_q   <= '0;
        end else if (take) begin
            mask_q   <= is_fault ? perm_t'('0) : mask_in;
            strobe_q <= is_fault;
            syn_q    <= syn_in;
            if (is_fault) begin
                addr_q <= addr_in;
            end
        end else begin
            strobe_q <= 1'b0;
        end
    end
endmodule

// File: rtl/npf_syn_enc.sv
// Nested page fault syndrome encoder (top). Resolves the walker fault class
// against the permission check, then registers the mask or the syndrome.
// Assumes the walker presents its inputs in the same cycle as in_valid.
module npf_syn_enc
    import npf_syn_pkg::*;
#(
    parameter int GPA_W = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              prot_user,
    input  logic              prot_write,
    input  logic              prot_nx,
    input  logic [1:0]        access_kind,
    input  logic [1:0]        walk_class,
    input  logic              walk_access,
    input  logic [GPA_W-1:0]  gpa,
    output logic [2:0]        perm_mask,
    output logic              fault_valid,
    output logic [63:0]       syndrome,
    output logic [GPA_W-1:0]  fault_gpa
);
    acc_kind_e          kind;
    fault_cls_e         wcls;
    fault_cls_e         eff_cls;
    logic               viol;
    perm_t              grant;
    perm_t              mask_q;
    logic [SYN_W-1:0]   syn_word;

    assign kind = acc_kind_e'(access_kind);
    assign wcls = fault_cls_e'(walk_class);

    npf_perm_check u_perm (
        .user_ok   (prot_user),
        .write_ok  (prot_write),
        .no_exec   (prot_nx),
        .kind      (kind),
        .violation (viol),
        .granted   (grant)
    );

    // A walker-reported class wins; otherwise a rights violation is a protection fault.
    always_comb begin
        if (wcls != FC_NONE) begin
            eff_cls = wcls;
        end else if (viol) begin
            eff_cls = FC_PROT;
        end else begin
            eff_cls = FC_NONE;
        end
    end

    npf_syn_build u_build (
        .cls        (eff_cls),
        .kind       (kind),
        .table_walk (walk_access),
        .word       (syn_word)
    );

    npf_out_reg #(.GPA_W(GPA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (in_valid),
        .is_fault (eff_cls != FC_NONE),
        .mask_in  (grant),
        .syn_in   (syn_word),
        .addr_in  (gpa),
        .mask_q   (mask_q),
        .strobe_q (fault_valid),
        .syn_q    (syndrome),
        .addr_q   (fault_gpa)
    );

    assign perm_mask = mask_q;
endmodule

// File: rtl/npf_syn_enc_chk.sv
// Property checker for npf_syn_enc, attached through bind.
module npf_syn_enc_chk #(
    parameter int GPA_W = 52
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              walk_access,
    input logic [2:0]        perm_mask,
    input logic              fault_valid,
    input logic [63:0]       syndrome,
    input logic [GPA_W-1:0]  fault_gpa
);
    // R1: outputs hold while no request is taken
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(perm_mask) && $stable(syndrome)));
    // R11: strobe comes only from a request in the previous cycle
    a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> $past(in_valid));
    // R11: no rights granted alongside a fault
    a_r11_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> perm_mask == 3'b000);
    // R7: user flag on every fault
    a_r7_user_flag: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> syndrome[2]);
    // R6: reserved-bit cascades into protection
    a_r6_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && syndrome[3]) |-> syndrome[0]);
    // R8: store and fetch flags never together
    a_r8_kind_excl: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> !(syndrome[1] && syndrome[4]));
    // R9: exactly one of final/table flags, chosen by the walk input
    a_r9_one_site: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> ($countones(syndrome[33:32]) == 1 && syndrome[33] == $past(walk_access)));
    // R10: the latched address changes only with a fault
    a_r10_gpa_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_gpa) |-> fault_valid);
endmodule

bind npf_syn_enc npf_syn_enc_chk #(.GPA_W(GPA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .walk_access (walk_access),
    .perm_mask   (perm_mask),
    .fault_valid (fault_valid),
    .syndrome    (syndrome),
    .fault_gpa   (fault_gpa)
);

// File: tb/npf_syn_enc_test.sv
// Exhaustive sweep bench for npf_syn_enc.
module npf_syn_enc_test;
    localparam int GPA_W = 52;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              prot_user = 1'b0;
    logic              prot_write = 1'b0;
    logic              prot_nx = 1'b0;
    logic [1:0]        access_kind = 2'd0;
    logic [1:0]        walk_class = 2'd0;
    logic              walk_access = 1'b0;
    logic [GPA_W-1:0]  gpa = '0;
    logic [2:0]        perm_mask;
    logic              fault_valid;
    logic [63:0]       syndrome;
    logic [GPA_W-1:0]  fault_gpa;

    int checks = 0;
    int fails  = 0;

    npf_syn_enc #(.GPA_W(GPA_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .prot_user(prot_user), .prot_write(prot_write), .prot_nx(prot_nx),
        .access_kind(access_kind), .walk_class(walk_class),
        .walk_access(walk_access), .gpa(gpa),
        .perm_mask(perm_mask), .fault_valid(fault_valid),
        .syndrome(syndrome), .fault_gpa(fault_gpa)
    );

    always #10 clk = ~clk;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [GPA_W-1:0] exp_gpa;
        exp_gpa = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(perm_mask == 3'b0 && !fault_valid && syndrome == 64'd0 && fault_gpa == '0,
            "R12", {60'd0, fault_valid, perm_mask}, 64'd0);
        rst_n = 1'b1;
        for (int c = 0; c < 256; c++) begin
            logic u, w, nx, wk, flt, rsv, pr;
            logic [1:0] acc, cls;
            logic [63:0] esyn;
            logic [2:0] emask, hmask;
            logic [63:0] hsyn;
            string why;
            u = c[0]; w = c[1]; nx = c[2]; acc = c[4:3]; cls = c[6:5]; wk = c[7];
            flt = (cls != 2'd0) || !u || (nx && acc == 2'd2) || (!w && acc == 2'd1);
            pr  = (cls == 2'd0) ? flt : (cls >= 2'd2);
            rsv = (cls == 2'd3);
            esyn = 64'd0;
            if (flt) begin
                esyn = {30'd0, wk, !wk, 27'd0, (acc == 2'd2), rsv, 1'b1, (acc == 2'd1), pr};
            end
            emask = flt ? 3'b000 : {!nx, w, 1'b1};
            if (cls != 2'd0) why = "R6";
            else if (!u) why = "R2";
            else if (nx && (acc == 2'd2 || !flt)) why = "R3";
            else if (!w && (acc == 2'd1 || !flt)) why = "R4";
            else why = "R5";
            in_valid = 1'b1; prot_user = u; prot_write = w; prot_nx = nx;
            access_kind = acc; walk_class = cls; walk_access = wk;
            gpa = 52'h3_0000_0000_0F00 + 52'(c) * 52'h1_0203_0405;
            if (flt) exp_gpa = gpa;
            @(negedge clk);
            chk(syndrome == esyn, why, syndrome, esyn);
            chk(perm_mask == emask, why, {61'd0, perm_mask}, {61'd0, emask});
            chk(fault_valid == flt, "R11", {63'd0, fault_valid}, {63'd0, flt});
            if (flt) begin
                chk(syndrome[2], "R7", syndrome, esyn);
                chk(syndrome[1] == (acc == 2'd1) && syndrome[4] == (acc == 2'd2), "R8", syndrome, esyn);
                chk(syndrome[33] == wk && syndrome[32] == !wk, "R9", syndrome, esyn);
            end
            chk(fault_gpa == exp_gpa, "R10", 64'(fault_gpa), 64'(exp_gpa));
            hmask = perm_mask; hsyn = syndrome;
            // idle cycle with all other inputs inverted: must be ignored
            in_valid = 1'b0; prot_user = !u; prot_write = !w; prot_nx = !nx;
            access_kind = ~acc; walk_class = ~cls; walk_access = !wk; gpa = ~gpa;
            @(negedge clk);
            chk(perm_mask == hmask && syndrome == hsyn, "R1", syndrome, hsyn);
            chk(!fault_valid, "R11", {63'd0, fault_valid}, 64'd0);
            chk(fault_gpa == exp_gpa, "R10", 64'(fault_gpa), 64'(exp_gpa));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule